// File: doc/BRIEF.md
# Tamper monitor with secure counter

This block is the always-powered security monitor of a chip. It keeps a seconds counter, driven by a fractional counter on the slow 32.768 kHz tick, and compares the seconds against an alarm value. It also holds a small security state made of two flags, non-valid and violation. Ten failure sources arrive as one-cycle pulses. When an enabled source fires, its detect bit and the violation flag are set, and every counter stops, so the seconds value records when the event happened. With both flags clear the unit is valid and keeps time.

Software talks to the block through a plain register port. Every write waits four slow ticks before it takes effect. A second write inside that window is refused and raises a write-error flag. Two resets act on the block: a battery-domain reset, which clears everything, and a system reset, which releases soft locks and moves a failed unit into the combined non-valid-plus-violation state. Recovery from a failure must then follow a fixed order: clear the detect bits, then the violation flag, then the non-valid flag.

Top module: `tamper_monitor`

## Requirements
- R1: After the battery-domain reset, the status register (address 5) reads 0x400: bit 10 is non-valid, and bit 11 violation, bits 9:0 detect, bit 12 alarm, bit 13 write-complete and bit 14 write-error are all clear. The seconds (address 0), control (address 3) and irq output are zero.
- R2: The seconds counter increases by one every 2^FRAC_W slow ticks. It does so only while control bit 0 (timer enable) is set and the non-valid, violation and detect bit 9 (timer overflow) flags are all clear. A committed write to the seconds register loads the seconds and zeroes the fraction (address 1).
- R3: A pulse on evt[i] while tamper-enable bit i (address 4) is set sets detect bit i and the violation flag. A pulse on a disabled source changes no status bit.
- R4: While the violation flag is set, the seconds and fraction stay unchanged, and writes to the seconds register are ignored.
- R5: When the seconds are all ones and a carry arrives, the seconds hold at all ones and detect bit 9 is set. If tamper-enable bit 9 is set, the violation flag is also set.
- R6: A write accepted in cycle k is applied at the clock edge that follows the fourth slow tick after k. Write-complete is then set, and it clears when the status register is read.
- R7: A write that arrives while another write is pending is dropped, and it sets write-error. The pending write still completes. Writing 1 to status bit 14 clears write-error.
- R8: Control bits 1 and 2 are the timer soft and hard locks, and bits 3 and 4 are the tamper soft and hard locks. Each lock bit can only be set by a write. While either timer lock is set, writes to timer enable and to the seconds register are ignored. While either tamper lock is set, writes to tamper-enable are ignored. The system reset clears the soft locks. Only the battery-domain reset clears the hard locks.
- R9: A system reset taken while violation is set also sets non-valid. The system reset clears the interrupt enables. Writes of 1 to the detect bits or to the violation bit are ignored unless non-valid is set.
- R10: The violation flag clears on a write of 1 only if no detect bit remains set afterwards. The non-valid flag clears on a write of 1 only if violation is already clear.
- R11: The alarm flag (status bit 12) is set when the seconds step onto the value in the alarm register (address 2). Writing 1 to bit 12 clears it.
- R12: irq is the OR of alarm, write-complete and violation, each ANDed with interrupt-enable bits 0, 1 and 2 (address 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| batt_rst | input | 1 | Battery-domain reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| slow_tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| evt | input | 10 | Failure-source pulses; bit 9 is the timer overflow source |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request |

## Verification
Read data appears one cycle after the read strobe. A write issued at edge k is visible to a read issued at edge k+6, and a read at edge k+5 still returns the old value. Flags set by a source pulse can be read two cycles later. In the bench the slow tick is held high every cycle. A read task pushes the expected value into a queue, and a monitor pops and compares the entry on the negative edge after each read strobe. The bench keeps exact cycle counts only where the requirement is about timing, as with the write-delay window and the zeroed fraction. Counts of seconds that run freely are checked against a window.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int DW       = 32;
    localparam int NSRC     = 10;
    localparam int SRC_TOVF = 9;
    localparam int ST_NV    = 10;
    localparam int ST_SV    = 11;
    localparam int ST_AL    = 12;
    localparam int ST_WC    = 13;
    localparam int ST_WE    = 14;
    localparam int STW      = ST_WE + 1;

    typedef enum logic [2:0] {
        A_SECS  = 3'd0,
        A_FRAC  = 3'd1,
        A_ALARM = 3'd2,
        A_CTRL  = 3'd3,
        A_TEN   = 3'd4,
        A_STAT  = 3'd5,
        A_IEN   = 3'd6,
        A_NONE  = 3'd7
    } addr_e;

    typedef struct packed {
        logic p_hard;
        logic p_soft;
        logic t_hard;
        logic t_soft;
        logic t_en;
    } ctrl_t;

    typedef struct packed {
        logic sv;
        logic wc;
        logic al;
    } ien_t;

    typedef struct packed {
        addr_e           addr;
        logic [DW-1:0]   data;
    } wr_t;

    function automatic logic [DW-1:0] pad_word(input logic [STW-1:0] v);
        return {{(DW-STW){1'b0}}, v};
    endfunction
endpackage

// File: rtl/tm_wrq.sv
module tm_wrq
    import tm_pkg::*;
#(
    parameter int WR_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  wr_t  req_w,
    output logic busy,
    output logic commit,
    output wr_t  cmt_w,
    output logic reject
);
    localparam int CW = $clog2(WR_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WR_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            commit <= 1'b0;
            reject <= 1'b0;
            cnt    <= '0;
            cmt_w  <= '{addr: A_NONE, data: '0};
        end else begin
            commit <= 1'b0;
            reject <= req && busy;
            if (busy) begin
                if (tick) begin
                    if (cnt == LAST) begin
                        busy   <= 1'b0;
                        commit <= 1'b1;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else if (req) begin
                busy  <= 1'b1;
                cmt_w <= req_w;
                cnt   <= '0;
            end
        end
    end

    a_r6_commit_follows_busy: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(busy));
endmodule

// File: rtl/tm_time.sv
module tm_time #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic [SEC_W-1:0] alarm_val,
    output logic [SEC_W-1:0] secs,
    output logic [FRAC_W-1:0] frac,
    output logic             alarm_step,
    output logic             ovf_step
);
    localparam logic [SEC_W-1:0]  SEC_MAX  = '1;
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

    logic carry;
    logic [SEC_W-1:0] secs_inc;

    always_comb begin
        carry      = !load && run && tick && (frac == FRAC_MAX);
        secs_inc   = secs + 1'b1;
        ovf_step   = carry && (secs == SEC_MAX);
        alarm_step = carry && (secs != SEC_MAX) && (secs_inc == alarm_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            secs <= '0;
            frac <= '0;
        end else if (load) begin
            secs <= load_val;
            frac <= '0;
        end else if (run && tick) begin
            frac <= frac + 1'b1;
            if (carry && (secs != SEC_MAX))
                secs <= secs_inc;
        end
    end

    a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> ($stable(secs) && $stable(frac)));

    a_r5_saturate_at_max: assert property (@(posedge clk) disable iff (rst)
        (secs == SEC_MAX && !load) |=> (secs == SEC_MAX));
endmodule

// File: rtl/tm_state.sv
module tm_state
    import tm_pkg::*;
(
    input  logic            clk,
    input  logic            batt_rst,
    input  logic            sys_rst,
    input  logic [NSRC-1:0] evt,
    input  logic            ovf_step,
    input  logic            alarm_step,
    input  logic            commit,
    input  addr_e           cmt_a,
    input  logic [STW-1:0]  cmt_d,
    input  logic            reject,
    input  logic            stat_rd,
    output ctrl_t           ctrl,
    output logic [NSRC-1:0] ten,
    output ien_t            ien,
    output logic [STW-1:0]  status,
    output logic            run,
    output logic            secs_wr_ok
);
    logic [NSRC-1:0] det, det_nx, det_clr, src;
    logic nv, sv, al, wc, we;
    logic nv_nx, sv_nx, al_nx, wc_nx, we_nx;
    logic wr_ctrl, wr_ten, wr_ien, wr_stat;
    logic t_locked, p_locked;
    ctrl_t cw;

    always_comb begin
        wr_ctrl  = commit && (cmt_a == A_CTRL);
        wr_ten   = commit && (cmt_a == A_TEN);
        wr_ien   = commit && (cmt_a == A_IEN);
        wr_stat  = commit && (cmt_a == A_STAT);
        cw       = ctrl_t'(cmt_d[4:0]);
        t_locked = ctrl.t_soft || ctrl.t_hard;
        p_locked = ctrl.p_soft || ctrl.p_hard;

        src            = evt;
        src[SRC_TOVF]  = evt[SRC_TOVF] || ovf_step;
        det_clr = (wr_stat && nv) ? cmt_d[NSRC-1:0] : '0;
        det_nx  = (det & ~det_clr) | (evt & ten);
        if (ovf_step)
            det_nx[SRC_TOVF] = 1'b1;

        if (|(src & ten))
            sv_nx = 1'b1;
        else if (wr_stat && nv && cmt_d[ST_SV] && (det_nx == '0))
            sv_nx = 1'b0;
        else
            sv_nx = sv;

        nv_nx = (wr_stat && cmt_d[ST_NV] && !sv) ? 1'b0 : nv;
        al_nx = alarm_step || (al && !(wr_stat && cmt_d[ST_AL]));
        we_nx = reject || (we && !(wr_stat && cmt_d[ST_WE]));
        wc_nx = commit || (wc && !stat_rd);

        run        = ctrl.t_en && !nv && !sv && !det[SRC_TOVF];
        secs_wr_ok = !t_locked && !sv;
        status     = {we, wc, al, sv, nv, det};
    end

    always_ff @(posedge clk) begin
        if (batt_rst) begin
            ctrl <= '0;
            ten  <= '0;
            ien  <= '0;
            det  <= '0;
            nv   <= 1'b1;
            sv   <= 1'b0;
            al   <= 1'b0;
            wc   <= 1'b0;
            we   <= 1'b0;
        end else if (sys_rst) begin
            ctrl.t_soft <= 1'b0;
            ctrl.p_soft <= 1'b0;
            ien         <= '0;
            wc          <= 1'b0;
            we          <= 1'b0;
            if (sv)
                nv <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                if (!t_locked)
                    ctrl.t_en <= cw.t_en;
                ctrl.t_soft <= ctrl.t_soft | cw.t_soft;
                ctrl.t_hard <= ctrl.t_hard | cw.t_hard;
                ctrl.p_soft <= ctrl.p_soft | cw.p_soft;
                ctrl.p_hard <= ctrl.p_hard | cw.p_hard;
            end
            if (wr_ten && !p_locked)
                ten <= cmt_d[NSRC-1:0];
            if (wr_ien)
                ien <= ien_t'(cmt_d[2:0]);
            det <= det_nx;
            sv  <= sv_nx;
            nv  <= nv_nx;
            al  <= al_nx;
            wc  <= wc_nx;
            we  <= we_nx;
        end
    end

    a_r10_violation_needs_clean_detect: assert property (@(posedge clk) disable iff (batt_rst)
        $fell(sv) |-> (det == '0));

    a_r10_nonvalid_after_violation: assert property (@(posedge clk) disable iff (batt_rst)
        $fell(nv) |-> !$past(sv));

    a_r8_hard_lock_holds_enables: assert property (@(posedge clk) disable iff (batt_rst)
        ctrl.p_hard |=> $stable(ten));

    a_r9_sysrst_in_failure: assert property (@(posedge clk) disable iff (batt_rst)
        (sys_rst && sv) |=> (nv && sv));
endmodule

// File: rtl/tamper_monitor.sv
module tamper_monitor
    import tm_pkg::*;
#(
    parameter int SEC_W    = 32,
    parameter int FRAC_W   = 15,
    parameter int WR_TICKS = 4
) (
    input  logic        clk,
    input  logic        batt_rst,
    input  logic        sys_rst,
    input  logic        slow_tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic [9:0]  evt,
    output logic [31:0] rdata,
    output logic        irq
);
    wr_t              req_w, cmt_w;
    logic             busy, commit, reject, stat_rd;
    logic             run, secs_wr_ok, load, alarm_step, ovf_step;
    logic [SEC_W-1:0] secs, alarm;
    logic [FRAC_W-1:0] frac;
    ctrl_t            ctrl;
    ien_t             ien;
    logic [NSRC-1:0]  ten;
    logic [STW-1:0]   status;

    always_comb begin
        req_w   = '{addr: addr_e'(addr), data: wdata};
        stat_rd = rd_en && (addr_e'(addr) == A_STAT);
        load    = commit && (cmt_w.addr == A_SECS) && secs_wr_ok;
        irq     = (status[ST_AL] && ien.al) || (status[ST_WC] && ien.wc)
               || (status[ST_SV] && ien.sv);
    end

    tm_wrq #(.WR_TICKS(WR_TICKS)) u_wrq (
        .clk(clk), .rst(batt_rst || sys_rst), .tick(slow_tick),
        .req(wr_en), .req_w(req_w), .busy(busy), .commit(commit),
        .cmt_w(cmt_w), .reject(reject)
    );

    tm_time #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_time (
        .clk(clk), .rst(batt_rst), .tick(slow_tick), .run(run),
        .load(load), .load_val(cmt_w.data[SEC_W-1:0]), .alarm_val(alarm),
        .secs(secs), .frac(frac), .alarm_step(alarm_step), .ovf_step(ovf_step)
    );

    tm_state u_state (
        .clk(clk), .batt_rst(batt_rst), .sys_rst(sys_rst), .evt(evt),
        .ovf_step(ovf_step), .alarm_step(alarm_step), .commit(commit),
        .cmt_a(cmt_w.addr), .cmt_d(cmt_w.data[STW-1:0]), .reject(reject),
        .stat_rd(stat_rd), .ctrl(ctrl), .ten(ten), .ien(ien),
        .status(status), .run(run), .secs_wr_ok(secs_wr_ok)
    );

    always_ff @(posedge clk) begin
        if (batt_rst)
            alarm <= '0;
        else if (commit && (cmt_w.addr == A_ALARM))
            alarm <= cmt_w.data[SEC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (batt_rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr_e'(addr))
                A_SECS:  rdata <= DW'(secs);
                A_FRAC:  rdata <= DW'(frac);
                A_ALARM: rdata <= DW'(alarm);
                A_CTRL:  rdata <= DW'(ctrl);
                A_TEN:   rdata <= DW'(ten);
                A_STAT:  rdata <= pad_word(status);
                A_IEN:   rdata <= DW'(ien);
                default: rdata <= '0;
            endcase
        end
    end

    a_r7_second_write_flags_error: assert property (@(posedge clk) disable iff (batt_rst || sys_rst)
        (wr_en && busy) |=> ##1 status[ST_WE]);

    a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (batt_rst)
        (ien == '0) |-> !irq);
endmodule

// File: tb/test_tamper_monitor.sv
module test_tamper_monitor;
    logic        clk = 1'b0;
    logic        batt_rst, sys_rst, slow_tick, wr_en, rd_en;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;
    logic [9:0]  evt;
    logic        irq;

    int vecs = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] mask;
        logic [31:0] lo;
        logic [31:0] hi;
        bit          skip;
        string       tag;
    } item_t;
    item_t q[$];
    logic rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    tamper_monitor #(.SEC_W(32), .FRAC_W(3), .WR_TICKS(4)) i_tamper_monitor (
        .clk(clk), .batt_rst(batt_rst), .sys_rst(sys_rst), .slow_tick(slow_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .evt(evt),
        .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expected item, got %h", rdata);
            end else begin
                item_t it;
                logic [31:0] v;
                it = q.pop_front();
                if (!it.skip) begin
                    vecs++;
                    v = rdata & it.mask;
                    if (v < it.lo || v > it.hi) begin
                        fails++;
                        $display("FAIL %s: got %h expected %h..%h", it.tag, v, it.lo, it.hi);
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_timed(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_timed(a, d);
        idle(4);
    endtask

    task automatic rd_rng(input logic [2:0] a, input logic [31:0] m,
                          input logic [31:0] lo, input logic [31:0] hi, input string tag);
        q.push_back('{mask: m, lo: lo, hi: hi, skip: 1'b0, tag: tag});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] m,
                          input logic [31:0] e, input string tag);
        rd_rng(a, m, e, e, tag);
    endtask

    task automatic rd_get(input logic [2:0] a, output logic [31:0] v);
        q.push_back('{mask: '0, lo: '0, hi: '0, skip: 1'b1, tag: ""});
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk_pin(input logic got, input logic exp, input string tag);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic pulse(input logic [9:0] bits);
        evt = bits;
        @(negedge clk);
        evt = '0;
        idle(2);
    endtask

    task automatic sys_pulse();
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        idle(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        batt_rst = 1'b1; sys_rst = 1'b1; slow_tick = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt = '0;
        idle(4);
        batt_rst = 1'b0; sys_rst = 1'b0;
        idle(1);

        // R1 reset state
        rd_chk(5, 32'h7FFF, 32'h400, "R1 status after battery reset");
        rd_chk(0, 32'hFFFFFFFF, 0, "R1 seconds after battery reset");
        rd_chk(3, 32'h1F, 0, "R1 control after battery reset");
        chk_pin(irq, 1'b0, "R1 irq after battery reset");

        // R2 no counting while non-valid
        wr(3, 32'h1);
        idle(30);
        rd_chk(0, 32'hFFFFFFFF, 0, "R2 no count while non-valid");

        // leave non-valid; R6 write-complete
        wr(5, 32'h400);
        rd_chk(5, 32'h7FFF, 32'h2000, "R6 write-complete set, unit valid");
        rd_chk(5, 32'h7FFF, 32'h0, "R6 write-complete cleared by status read");

        // R2 load zeroes fraction, then counting
        wr_timed(0, 100);
        idle(1);
        rd_chk(1, 32'hFFFFFFFF, 0, "R2 fraction zeroed by seconds write");
        rd_chk(0, 32'hFFFFFFFF, 100, "R2 seconds loaded");
        idle(80);
        rd_rng(0, 32'hFFFFFFFF, 109, 112, "R2 seconds advance once per 8 ticks");

        // R11 / R12 alarm
        wr(2, 300);
        wr(0, 295);
        rd_chk(5, 32'h1000, 0, "R11 no alarm before match");
        wr(6, 32'h1);
        chk_pin(irq, 1'b0, "R12 irq low without alarm");
        idle(60);
        rd_chk(5, 32'h1000, 32'h1000, "R11 alarm flag at match");
        chk_pin(irq, 1'b1, "R12 alarm irq");
        wr(5, 32'h1000);
        chk_pin(irq, 1'b0, "R12 irq drops after alarm cleared");

        // R7 back-to-back write
        wr_en = 1'b1; addr = 2; wdata = 7;
        @(negedge clk);
        wdata = 9;
        @(negedge clk);
        wr_en = 1'b0;
        idle(8);
        rd_chk(2, 32'hFFFFFFFF, 7, "R7 pending write completes, second dropped");
        rd_chk(5, 32'h4000, 32'h4000, "R7 write-error set");
        wr(5, 32'h4000);
        rd_chk(5, 32'h4000, 0, "R7 write-error cleared");

        // R6 exact delay
        wr_timed(2, 33);
        rd_chk(2, 32'hFFFFFFFF, 7, "R6 old value before delay ends");
        rd_chk(2, 32'hFFFFFFFF, 33, "R6 new value after four ticks");

        // R3 sources
        wr(4, 32'h1);
        pulse(10'h002);
        rd_chk(5, 32'hFFF, 0, "R3 disabled source ignored");
        wr(6, 32'h4);
        pulse(10'h001);
        rd_chk(5, 32'hFFF, 32'h801, "R3 detect and violation set");
        chk_pin(irq, 1'b1, "R12 violation irq");

        // R4 freeze
        rd_get(0, v);
        idle(40);
        rd_chk(0, 32'hFFFFFFFF, v, "R4 seconds frozen in failure");
        rd_get(1, v);
        idle(20);
        rd_chk(1, 32'hFFFFFFFF, v, "R4 fraction frozen in failure");
        rd_get(0, v);
        wr(0, 5);
        rd_chk(0, 32'hFFFFFFFF, v, "R4 seconds write ignored in failure");

        // R9 clear ignored without non-valid
        wr(5, 32'hFFF);
        rd_chk(5, 32'hFFF, 32'h801, "R9 clear ignored without non-valid");

        // R8 soft locks
        wr(3, 32'h0B);
        wr(3, 32'h08);
        rd_chk(3, 32'h1F, 32'h0B, "R8 timer enable held by timer soft lock");
        wr(4, 32'h3FF);
        rd_chk(4, 32'hFFFFFFFF, 32'h1, "R8 tamper enable held by soft lock");
        sys_pulse();
        rd_chk(5, 32'hFFF, 32'hC01, "R9 system reset in failure sets non-valid");
        rd_chk(3, 32'h1F, 32'h01, "R8 system reset releases soft locks");
        chk_pin(irq, 1'b0, "R9 system reset clears interrupt enables");
        wr(4, 32'h3FF);
        rd_chk(4, 32'hFFFFFFFF, 32'h3FF, "R8 tamper enable writable after release");
        wr(3, 32'h11);
        wr(4, 32'h1);
        rd_chk(4, 32'hFFFFFFFF, 32'h3FF, "R8 tamper enable held by hard lock");
        sys_pulse();
        rd_chk(3, 32'h1F, 32'h11, "R8 hard lock survives system reset");
        wr(4, 32'h1);
        rd_chk(4, 32'hFFFFFFFF, 32'h3FF, "R8 hard lock still blocks writes");

        // R10 recovery order
        rd_get(0, v);
        wr(5, 32'h800);
        rd_chk(5, 32'hFFF, 32'hC01, "R10 violation held while detect set");
        wr(5, 32'h400);
        rd_chk(5, 32'hFFF, 32'hC01, "R10 non-valid held while violation set");
        wr(5, 32'h001);
        rd_chk(5, 32'hFFF, 32'hC00, "R10 detect cleared in combined state");
        wr(5, 32'h800);
        rd_chk(5, 32'hFFF, 32'h400, "R10 violation cleared");
        wr(5, 32'h400);
        rd_chk(5, 32'hFFF, 32'h000, "R10 non-valid cleared, unit valid");
        idle(40);
        rd_rng(0, 32'hFFFFFFFF, v + 3, v + 7, "R2 counting resumes after recovery");

        // R5 overflow
        wr(0, 32'hFFFFFFFE);
        idle(40);
        rd_chk(0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R5 seconds saturate");
        rd_chk(5, 32'hFFF, 32'hA00, "R5 overflow detect and violation");
        idle(20);
        rd_chk(0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R5 seconds stay saturated");

        // battery reset
        batt_rst = 1'b1;
        idle(2);
        batt_rst = 1'b0;
        idle(1);
        rd_chk(3, 32'h1F, 0, "R8 battery reset releases hard lock");
        rd_chk(5, 32'h7FFF, 32'h400, "R1 status after second battery reset");

        while (q.size() != 0) @(negedge clk);
        idle(2);
        finish_run();
    end
endmodule